// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block is a passive observer on the command bus of a four-bank SDRAM. On every rising clock edge it decodes the command from clock enable, chip select, the three strobes, the bank address and the address bus. It follows each bank's idle or open state and which row is open, and it reports any command that breaks bank-state legality or arrives too soon after an earlier one. All spacing limits are inputs counted in clocks, so one instance serves any speed grade or clock rate. The block does not model data storage or data-pin timing.

Each rule has its own bit. A bit pulses for one cycle in `err_pulse` in the cycle after the offending edge, and the same bit is held in `err_sticky` until reset. Each bank keeps its own state and counters. A single tracker shared by the banks covers the spacing between activates to different banks and the quiet period after a mode-register write.

Rule bit positions: 0 row-to-column, 1 activate-to-activate (different banks), 2 minimum open time, 3 maximum open time, 4 activate-to-activate (same bank), 5 precharge-to-activate, 6 mode-register quiet period, 7 illegal state. The command code is {ras_n,cas_n,we_n} with cs_n low and cke high: 000 mode write, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. Address bit 10 selects all banks on a precharge and automatic close on a read or write. A spacing of d means the second command is sampled d edges after the first.

Top module: `sdram_timing_monitor`

## Requirements
- R1: A cycle with cs_n high or cke low is not a command: it opens no bank, restarts no timer and raises no bit except bit 3.
- R2: A read or write to an open bank fewer than t_rcd edges after that bank's activate sets bit 0.
- R3: An activate fewer than t_rrd edges after an activate to a different bank sets bit 1.
- R4: A precharge that closes an open bank fewer than t_ras edges after its activate sets bit 2.
- R5: A bank still open t_ras_max+1 edges after its activate sets bit 3 once, at that edge, with no command needed.
- R6: An activate fewer than t_rc edges after the previous activate to the same bank sets bit 4.
- R7: An activate fewer than t_rp edges after that bank was closed sets bit 5; a precharge with address bit 10 high closes every open bank.
- R8: Any command other than no-op fewer than t_mrd edges after a mode-register write sets bit 6.
- R9: A read or write to an idle bank, an activate to an open bank, or a refresh or mode-register write while any bank is open sets bit 7.
- R10: A read or write with address bit 10 high closes its bank burst_len edges later, and the t_rp window starts at that edge.
- R11: err_pulse shows only the violations of the previous edge, err_sticky keeps every bit once set, and bank_open and bank_row report each bank's state and open row.
- R12: Reset clears err_pulse and err_sticky, marks all banks idle, and arms all timers as expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low means no command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba | input | BW | Bank address |
| addr | input | RW | Row or column address; bit 10 is the all-bank / auto-close flag |
| t_rcd | input | CW | Activate to read/write, clocks |
| t_rrd | input | CW | Activate to activate across banks, clocks |
| t_ras | input | CW | Minimum open time, clocks |
| t_rc | input | CW | Activate to activate in one bank, clocks |
| t_rp | input | CW | Close to activate, clocks |
| t_mrd | input | CW | Mode write to next command, clocks |
| burst_len | input | CW | Burst length for auto close (0 treated as 1) |
| t_ras_max | input | TW | Maximum open time, clocks |
| err_pulse | output | 8 | Per-rule violation pulse |
| err_sticky | output | 8 | Per-rule accumulated violations |
| bank_open | output | 2**BW | Open flag per bank |
| bank_row | output | 2**BW*RW | Open row per bank, bank 0 in the low bits |

## Verification
The hardest case to reach is the automatic close. No command appears on the bus when it happens: the bank closes burst_len edges after the read, and the t_rp window has to be measured from that silent edge. The bench issues a read with bit 10 high and watches bank_open fall on the predicted edge. It then sweeps the next activate across the edges around the end of the window, so that an off-by-one in the close countdown or in the restart of the precharge timer changes the expected bit. The maximum-open rule is reached the same way, by sampling every idle cycle around t_ras_max.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NONE,   // clock enable low: nothing registered
    CMD_DESEL,
    CMD_NOP,
    CMD_MRS,
    CMD_REF,
    CMD_PRE,
    CMD_ACT,
    CMD_WR,
    CMD_RD,
    CMD_BST
  } cmd_e;

  localparam int NRULE    = 8;
  localparam int R_RCD    = 0;
  localparam int R_RRD    = 1;
  localparam int R_RASMIN = 2;
  localparam int R_RASMAX = 3;
  localparam int R_RC     = 4;
  localparam int R_RP     = 5;
  localparam int R_MRD    = 6;
  localparam int R_STATE  = 7;

  function automatic cmd_e decode_cmd(input logic cke, input logic cs_n,
                                      input logic ras_n, input logic cas_n,
                                      input logic we_n);
    if (!cke) return CMD_NONE;
    if (cs_n) return CMD_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b000:  return CMD_MRS;
      3'b001:  return CMD_REF;
      3'b010:  return CMD_PRE;
      3'b011:  return CMD_ACT;
      3'b100:  return CMD_WR;
      3'b101:  return CMD_RD;
      3'b110:  return CMD_BST;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic logic is_real_cmd(input cmd_e c);
    return !(c == CMD_NONE || c == CMD_DESEL || c == CMD_NOP);
  endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int CW = 5,
  parameter int TW = 16,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic          sel,
  input  logic          a10,
  input  logic [RW-1:0] row_in,
  input  logic [CW-1:0] lim_rcd,
  input  logic [CW-1:0] lim_ras,
  input  logic [CW-1:0] lim_rc,
  input  logic [CW-1:0] lim_rp,
  input  logic [CW-1:0] burst_len,
  input  logic [TW-1:0] lim_ras_max,
  output logic          is_open,
  output logic [RW-1:0] row_q,
  output logic          ev_rcd,
  output logic          ev_ras_min,
  output logic          ev_ras_max,
  output logic          ev_rc,
  output logic          ev_rp,
  output logic          ev_state
);

  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [CW-1:0] CMAX = '1;

  function automatic logic [TW-1:0] bump_t(input logic [TW-1:0] v);
    return (v == TMAX) ? v : v + TW'(1);
  endfunction

  function automatic logic [CW-1:0] bump_c(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + CW'(1);
  endfunction

  logic [TW-1:0] act_cnt;   // edges since this bank's last activate
  logic [CW-1:0] pre_cnt;   // edges since this bank last closed
  logic [CW-1:0] ap_cnt;    // auto-close countdown, 0 = none pending
  logic          open_q;

  logic is_act, is_rw, is_pre, ap_fire, do_open, do_close, arm_ap;
  logic [CW-1:0] ap_len;

  always_comb begin
    is_act   = sel && (cmd == CMD_ACT);
    is_rw    = sel && (cmd == CMD_RD || cmd == CMD_WR);
    is_pre   = (cmd == CMD_PRE) && (sel || a10);
    ap_fire  = (ap_cnt == CW'(1));
    ap_len   = (burst_len == '0) ? CW'(1) : burst_len;
    do_open  = is_act && !open_q;
    do_close = (is_pre && open_q) || ap_fire;
    arm_ap   = is_rw && open_q && a10 && (ap_cnt == '0);
  end

  always_comb begin
    ev_state   = (is_act && open_q) || (is_rw && !open_q);
    ev_rcd     = is_rw && open_q && (act_cnt < TW'(lim_rcd));
    ev_rc      = is_act && (act_cnt < TW'(lim_rc));
    ev_rp      = is_act && (pre_cnt < lim_rp);
    ev_ras_min = is_pre && open_q && (act_cnt < TW'(lim_ras));
    ev_ras_max = open_q && ({1'b0, act_cnt} == ({1'b0, lim_ras_max} + (TW+1)'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      row_q   <= '0;
      act_cnt <= TMAX;
      pre_cnt <= CMAX;
      ap_cnt  <= '0;
    end else begin
      act_cnt <= bump_t(act_cnt);
      pre_cnt <= bump_c(pre_cnt);
      if (ap_cnt != '0) ap_cnt <= ap_cnt - CW'(1);
      if (do_open) begin
        open_q  <= 1'b1;
        row_q   <= row_in;
        act_cnt <= TW'(1);
      end
      if (do_close) begin
        open_q  <= 1'b0;
        pre_cnt <= CW'(1);
        ap_cnt  <= '0;
      end else if (arm_ap) begin
        ap_cnt  <= ap_len;
      end
    end
  end

  assign is_open = open_q;

endmodule

// File: rtl/sdram_bus_track.sv
module sdram_bus_track
  import sdram_mon_pkg::*;
#(
  parameter int CW = 5,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic [BW-1:0] ba,
  input  logic [CW-1:0] lim_rrd,
  input  logic [CW-1:0] lim_mrd,
  output logic          ev_rrd,
  output logic          ev_mrd
);

  localparam logic [CW-1:0] CMAX = '1;

  function automatic logic [CW-1:0] bump_c(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + CW'(1);
  endfunction

  logic [CW-1:0] rrd_cnt;   // edges since any activate
  logic [CW-1:0] mrd_cnt;   // edges since mode-register write
  logic [BW-1:0] last_ba;

  always_comb begin
    ev_rrd = (cmd == CMD_ACT) && (ba != last_ba) && (rrd_cnt < lim_rrd);
    ev_mrd = is_real_cmd(cmd) && (mrd_cnt < lim_mrd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt <= CMAX;
      mrd_cnt <= CMAX;
      last_ba <= '0;
    end else begin
      rrd_cnt <= bump_c(rrd_cnt);
      mrd_cnt <= bump_c(mrd_cnt);
      if (cmd == CMD_ACT) begin
        rrd_cnt <= CW'(1);
        last_ba <= ba;
      end
      if (cmd == CMD_MRS) mrd_cnt <= CW'(1);
    end
  end

endmodule

// File: rtl/sdram_timing_monitor.sv
module sdram_timing_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BW = 2,
  parameter int RW = 12,
  parameter int CW = 5,
  parameter int TW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [BW-1:0]         ba,
  input  logic [RW-1:0]         addr,
  input  logic [CW-1:0]         t_rcd,
  input  logic [CW-1:0]         t_rrd,
  input  logic [CW-1:0]         t_ras,
  input  logic [CW-1:0]         t_rc,
  input  logic [CW-1:0]         t_rp,
  input  logic [CW-1:0]         t_mrd,
  input  logic [CW-1:0]         burst_len,
  input  logic [TW-1:0]         t_ras_max,
  output logic [NRULE-1:0]      err_pulse,
  output logic [NRULE-1:0]      err_sticky,
  output logic [(1<<BW)-1:0]    bank_open,
  output logic [(1<<BW)*RW-1:0] bank_row
);

  localparam int NB     = 1 << BW;
  localparam int AP_BIT = 10;

  cmd_e cmd;
  always_comb cmd = decode_cmd(cke, cs_n, ras_n, cas_n, we_n);

  logic [NB-1:0] rcd_v, rasmin_v, rasmax_v, rc_v, rp_v, state_v;
  logic          ev_rrd, ev_mrd, state_bus;
  logic [NRULE-1:0] viol_now;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    sdram_bank_track #(.CW(CW), .TW(TW), .RW(RW)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .sel        (ba == BW'(b)),
      .a10        (addr[AP_BIT]),
      .row_in     (addr),
      .lim_rcd    (t_rcd),
      .lim_ras    (t_ras),
      .lim_rc     (t_rc),
      .lim_rp     (t_rp),
      .burst_len  (burst_len),
      .lim_ras_max(t_ras_max),
      .is_open    (bank_open[b]),
      .row_q      (bank_row[b*RW +: RW]),
      .ev_rcd     (rcd_v[b]),
      .ev_ras_min (rasmin_v[b]),
      .ev_ras_max (rasmax_v[b]),
      .ev_rc      (rc_v[b]),
      .ev_rp      (rp_v[b]),
      .ev_state   (state_v[b])
    );
  end

  sdram_bus_track #(.CW(CW), .BW(BW)) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .ba     (ba),
    .lim_rrd(t_rrd),
    .lim_mrd(t_mrd),
    .ev_rrd (ev_rrd),
    .ev_mrd (ev_mrd)
  );

  always_comb begin
    state_bus          = (cmd == CMD_MRS || cmd == CMD_REF) && (|bank_open);
    viol_now           = '0;
    viol_now[R_RCD]    = |rcd_v;
    viol_now[R_RRD]    = ev_rrd;
    viol_now[R_RASMIN] = |rasmin_v;
    viol_now[R_RASMAX] = |rasmax_v;
    viol_now[R_RC]     = |rc_v;
    viol_now[R_RP]     = |rp_v;
    viol_now[R_MRD]    = ev_mrd;
    viol_now[R_STATE]  = (|state_v) || state_bus;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse  <= '0;
      err_sticky <= '0;
    end else begin
      err_pulse  <= viol_now;
      err_sticky <= err_sticky | viol_now;
    end
  end

endmodule

// File: rtl/sdram_timing_monitor_chk.sv
module sdram_timing_monitor_chk
  import sdram_mon_pkg::*;
#(
  parameter int BW = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BW-1:0]        ba,
  input logic [NRULE-1:0]     err_pulse,
  input logic [NRULE-1:0]     err_sticky,
  input logic [(1<<BW)-1:0]   bank_open
);

  localparam logic [NRULE-1:0] OPEN_TIME_BIT = NRULE'(1) << R_RASMAX;

  a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_sticky & $past(err_sticky)) == $past(err_sticky)));

  a_r11_pulse_in_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |-> ((err_sticky & err_pulse) == err_pulse));

  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cke) |=> ((err_pulse & ~OPEN_TIME_BIT) == '0));

  a_r9_refresh_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && !ras_n && !cas_n && we_n && (|bank_open)) |=> err_pulse[R_STATE]);

  for (genvar b = 0; b < (1 << BW); b++) begin : g_open
    a_r9_open_needs_activate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_open[b]) |->
        $past(cke && !cs_n && !ras_n && cas_n && we_n && (ba == BW'(b))));
  end

endmodule

bind sdram_timing_monitor sdram_timing_monitor_chk #(.BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .err_pulse (err_pulse),
  .err_sticky(err_sticky),
  .bank_open (bank_open)
);

// File: tb/tb_sdram_timing_monitor.sv
module tb_sdram_timing_monitor;

  localparam int T_RCD = 3, T_RRD = 2, T_RAS = 5, T_RC = 7, T_RP = 3, T_MRD = 2;
  localparam int BL = 4, T_RASMAX = 20;

  localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                         K_ACT = 3'b011, K_WR = 3'b100, K_RD = 3'b101, K_NOP = 3'b111;

  localparam logic [7:0] B_RCD = 8'h01, B_RRD = 8'h02, B_RASMIN = 8'h04, B_RASMAX = 8'h08,
                         B_RC = 8'h10, B_RP = 8'h20, B_MRD = 8'h40, B_STATE = 8'h80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [7:0]  err_pulse, err_sticky;
  logic [3:0]  bank_open;
  logic [47:0] bank_row;
  logic [7:0]  pv;

  int checks = 0, errors = 0;
  bit done = 0;

  sdram_timing_monitor dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr),
    .t_rcd(5'(T_RCD)), .t_rrd(5'(T_RRD)), .t_ras(5'(T_RAS)), .t_rc(5'(T_RC)),
    .t_rp(5'(T_RP)), .t_mrd(5'(T_MRD)), .burst_len(5'(BL)), .t_ras_max(16'(T_RASMAX)),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .bank_open(bank_open), .bank_row(bank_row)
  );

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sampled at posedge, outputs read at next negedge
  task automatic raw(input logic ck, input logic csn, input logic [2:0] k,
                     input logic [1:0] b, input logic [11:0] a);
    cke = ck; cs_n = csn; {ras_n, cas_n, we_n} = k; ba = b; addr = a;
    @(negedge clk);
    pv = err_pulse;
    cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP; ba = '0; addr = '0;
  endtask

  task automatic cmd(input logic [2:0] k, input logic [1:0] b, input logic [11:0] a);
    raw(1'b1, 1'b0, k, b, a);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) cmd(K_NOP, 2'd0, 12'h000);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    reset_dut();
    chk("R12 sticky after reset", err_sticky, 0);
    chk("R12 pulse after reset", err_pulse, 0);
    chk("R12 banks idle after reset", bank_open, 0);

    // R2: row-to-column spacing sweep
    for (int d = 1; d <= 5; d++) begin
      reset_dut();
      cmd(K_ACT, 2'd0, 12'h123);
      nops(d - 1);
      cmd((d % 2) ? K_RD : K_WR, 2'd0, 12'h000);
      chk($sformatf("R2 rcd d=%0d", d), pv, (d < T_RCD) ? B_RCD : 8'h00);
    end

    // R3: activate spacing across banks
    for (int d = 1; d <= 3; d++) begin
      reset_dut();
      cmd(K_ACT, 2'd0, 12'h001);
      nops(d - 1);
      cmd(K_ACT, 2'd1, 12'h002);
      chk($sformatf("R3 rrd d=%0d", d), pv, (d < T_RRD) ? B_RRD : 8'h00);
    end

    // R4: minimum open time
    for (int d = 1; d <= 6; d++) begin
      reset_dut();
      cmd(K_ACT, 2'd2, 12'h010);
      nops(d - 1);
      cmd(K_PRE, 2'd2, 12'h000);
      chk($sformatf("R4 ras min d=%0d", d), pv, (d < T_RAS) ? B_RASMIN : 8'h00);
      chk($sformatf("R7 bank closed d=%0d", d), bank_open, 0);
    end

    // R6 / R7: same-bank activate after explicit precharge at edge 5
    for (int d = 6; d <= 9; d++) begin
      reset_dut();
      cmd(K_ACT, 2'd1, 12'h020);
      nops(4);
      cmd(K_PRE, 2'd1, 12'h000);
      nops(d - 6);
      cmd(K_ACT, 2'd1, 12'h021);
      chk($sformatf("R6 R7 rc rp d=%0d", d), pv,
          ((d < T_RC) ? B_RC : 8'h00) | (((d - 5) < T_RP) ? B_RP : 8'h00));
    end

    // R7: all-bank precharge
    reset_dut();
    cmd(K_ACT, 2'd0, 12'h030);
    nops(1);
    cmd(K_ACT, 2'd1, 12'h031);
    nops(5);
    cmd(K_PRE, 2'd3, 12'h400);
    chk("R7 all-bank precharge pulse", pv, 0);
    chk("R7 all-bank precharge closes", bank_open, 0);
    cmd(K_ACT, 2'd1, 12'h032);
    chk("R7 rp after all-bank precharge", pv, B_RP);
    nops(1);
    cmd(K_ACT, 2'd0, 12'h033);
    chk("R7 rp satisfied", pv, 0);

    // R5: maximum open time, no command needed
    reset_dut();
    cmd(K_ACT, 2'd3, 12'h040);
    for (int k = 1; k <= 25; k++) begin
      cmd(K_NOP, 2'd0, 12'h000);
      chk($sformatf("R5 ras max k=%0d", k), pv, (k == T_RASMAX + 1) ? B_RASMAX : 8'h00);
    end
    reset_dut();
    cmd(K_ACT, 2'd3, 12'h041);
    nops(T_RASMAX - 1);
    cmd(K_PRE, 2'd3, 12'h000);
    chk("R5 close at limit", pv, 0);
    nops(5);
    chk("R5 no late pulse", err_sticky, 0);

    // R8: mode-register quiet period
    for (int d = 1; d <= 3; d++) begin
      reset_dut();
      cmd(K_MRS, 2'd0, 12'h000);
      nops(d - 1);
      cmd(K_ACT, 2'd0, 12'h050);
      chk($sformatf("R8 mrd d=%0d", d), pv, (d < T_MRD) ? B_MRD : 8'h00);
    end
    reset_dut();
    cmd(K_MRS, 2'd0, 12'h000);
    cmd(K_NOP, 2'd0, 12'h000);
    chk("R8 no-op allowed", pv, 0);

    // R9: illegal states
    reset_dut();
    cmd(K_RD, 2'd1, 12'h000);
    chk("R9 read idle bank", pv, B_STATE);
    reset_dut();
    cmd(K_ACT, 2'd0, 12'h060);
    nops(8);
    cmd(K_ACT, 2'd0, 12'h061);
    chk("R9 activate open bank", pv, B_STATE);
    chk("R9 row kept", bank_row[11:0], 12'h060);
    cmd(K_REF, 2'd0, 12'h000);
    chk("R9 refresh with open bank", pv, B_STATE);
    cmd(K_MRS, 2'd0, 12'h000);
    chk("R9 mode write with open bank", pv, B_STATE);
    reset_dut();
    cmd(K_REF, 2'd0, 12'h000);
    chk("R9 refresh all idle", pv, 0);

    // R10: auto close at burst end, rp counted from there
    reset_dut();
    cmd(K_ACT, 2'd0, 12'h070);
    nops(2);
    cmd(K_RD, 2'd0, 12'h400);
    chk("R10 auto-close read", pv, 0);
    nops(3);
    chk("R10 open before burst end", bank_open, 4'b0001);
    cmd(K_NOP, 2'd0, 12'h000);
    chk("R10 closed at burst end", bank_open, 4'b0000);
    for (int e = 8; e <= 11; e++) begin
      reset_dut();
      cmd(K_ACT, 2'd0, 12'h071);
      nops(2);
      cmd(K_WR, 2'd0, 12'h400);
      nops(e - 4);
      cmd(K_ACT, 2'd0, 12'h072);
      chk($sformatf("R10 rp after auto close e=%0d", e), pv,
          ((e - 7) < T_RP) ? B_RP : 8'h00);
    end

    // R1: deselect and clock-enable low are ignored
    reset_dut();
    raw(1'b1, 1'b1, K_ACT, 2'd0, 12'h080);
    chk("R1 deselected activate pulse", pv, 0);
    chk("R1 deselected activate no open", bank_open, 0);
    raw(1'b0, 1'b0, K_ACT, 2'd0, 12'h081);
    chk("R1 cke low activate no open", bank_open, 0);
    cmd(K_ACT, 2'd0, 12'h082);
    raw(1'b1, 1'b1, K_RD, 2'd0, 12'h000);
    chk("R1 deselected read no rcd", pv, 0);
    cmd(K_RD, 2'd0, 12'h000);
    chk("R1 real read does trip rcd", pv, B_RCD);
    reset_dut();
    raw(1'b1, 1'b1, K_MRS, 2'd0, 12'h000);
    cmd(K_ACT, 2'd0, 12'h083);
    chk("R1 deselected mode write starts no mrd", pv, 0);

    // R11: pulse length, sticky retention, bank state report
    reset_dut();
    cmd(K_RD, 2'd1, 12'h000);
    chk("R11 pulse raised", pv, B_STATE);
    cmd(K_NOP, 2'd0, 12'h000);
    chk("R11 pulse one cycle", pv, 0);
    nops(5);
    chk("R11 sticky retained", err_sticky, B_STATE);
    cmd(K_ACT, 2'd2, 12'hABC);
    chk("R11 bank_open report", bank_open, 4'b0100);
    chk("R11 bank_row report", bank_row[35:24], 12'hABC);
    reset_dut();
    chk("R12 reset clears sticky", err_sticky, 0);
    chk("R12 reset closes banks", bank_open, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule